// File: doc/BRIEF.md
# Polyphase Scaler Phase-Step and Chroma Offset Calculator

This block turns a scaling request into the fixed-point setup words a polyphase image scaler needs. Its inputs are the source and destination luma sizes, a buffer format code for each side and a chroma siting code. From these it derives the subsampled chroma plane sizes. It then computes four phase increments: luma vertical, luma horizontal, chroma vertical and chroma horizontal. Each increment is the source size over the destination size in units of 1/8192, rounded to nearest. The block also produces the fractional chroma start phases and four resolution words, each holding a width and a height stored as minus one.

A one-cycle `start_i` pulse captures the request while the block is idle. The resolution words and start phases appear the cycle after capture. The four increments come from a single restoring divider that is reused four times in a fixed order. `done_o` pulses once after the last division. All outputs hold their values until the next accepted start. Luma start phases are always zero, so they are not brought out.

Top module: `scl_phase_calc`

## Requirements
- R1: Each luma increment equals (src·8192 + floor(dst/2)) / dst, truncated to its low 16 bits. Luma vertical uses the heights and luma horizontal uses the widths.
- R2: Format codes are 0 = 4:2:0, 1 = 4:2:2 and 2 = 4:4:4/RGB; code 3 behaves as 4:4:4. Source chroma width is half the luma width (floor) for codes 0 and 1. Source chroma height is half the luma height for code 0. Destination chroma width is half for code 1. Destination chroma height equals the luma height. The chroma increments apply the R1 formula to these chroma sizes.
- R3: `chr_vstart_o` (16 bits, two's complement) is 0xF800 for a 4:2:0 source with siting 0 or 1, and 0xF000 for a 4:2:0 source with siting 4 or 5. It is zero in every other case.
- R4: `chr_hstart_o` (19 bits, two's complement) is 0x7F800 for a 4:2:0 source with siting 1, 3 or 5, and zero otherwise.
- R5: Each resolution word holds (width−1) in bits [11:0] and (height−1) in bits [27:16]; all other bits are zero. The four words describe source luma, source chroma, destination luma and destination chroma, each using the sizes from R2.
- R6: When the source format is 4:4:4 (code 2 or 3) and the destination is 4:2:2, the source luma and source chroma heights are each reduced by one before encoding. The increments are computed from the unreduced heights.
- R7: `busy_o` rises the cycle after an accepted start and falls on the cycle `done_o` is high. `done_o` is high for exactly one cycle. A start pulse that arrives while `busy_o` is high is ignored.
- R8: Between runs, every result output holds its value regardless of any input change. Inputs are sampled only at the accepted start.
- R9: After reset, `busy_o`, `done_o` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| src_w_i | input | 12 | Source luma width |
| src_h_i | input | 12 | Source luma height |
| dst_w_i | input | 12 | Destination luma width |
| dst_h_i | input | 12 | Destination luma height |
| src_fmt_i | input | 2 | Source format code |
| dst_fmt_i | input | 2 | Destination format code |
| siting_i | input | 3 | Source chroma siting code |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse when all increments are valid |
| luma_vinc_o | output | 16 | Luma vertical increment |
| luma_hinc_o | output | 16 | Luma horizontal increment |
| chr_vinc_o | output | 16 | Chroma vertical increment |
| chr_hinc_o | output | 16 | Chroma horizontal increment |
| chr_vstart_o | output | 16 | Chroma vertical start phase |
| chr_hstart_o | output | 19 | Chroma horizontal start phase |
| src_luma_res_o | output | 32 | Source luma resolution word |
| src_chr_res_o | output | 32 | Source chroma resolution word |
| dst_luma_res_o | output | 32 | Destination luma resolution word |
| dst_chr_res_o | output | 32 | Destination chroma resolution word |

## Verification
Two kinds of internal fault show up differently at the ports. A corrupted divider remainder or bit counter gives a wrong increment, and that is visible at the single `done_o` sample of that run. A sequencer that stores a quotient into the wrong slot swaps two increments; this shows whenever the luma and chroma sizes differ, which the format sweep ensures happens often. A fault in the capture path, such as taking a start while busy or reading live inputs, shows as results that follow the second configuration or drift after `done_o`. Both are checked within a few cycles of the disturbance.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;
  typedef enum logic [1:0] {
    FMT_420 = 2'd0,
    FMT_422 = 2'd1,
    FMT_444 = 2'd2,
    FMT_RSV = 2'd3
  } pix_fmt_e;

  localparam int unsigned RES_FLD_W  = 12;
  localparam int unsigned RES_H_LSB  = 16;
  localparam int unsigned RES_WORD_W = 32;

  function automatic logic [RES_WORD_W-1:0] enc_res(input logic [RES_FLD_W-1:0] w,
                                                    input logic [RES_FLD_W-1:0] h);
    logic [RES_WORD_W-1:0] word;
    word = '0;
    word[RES_FLD_W-1:0]                 = w - 1'b1;
    word[RES_H_LSB+RES_FLD_W-1:RES_H_LSB] = h - 1'b1;
    return word;
  endfunction
endpackage

// File: rtl/scl_chroma_geom.sv
module scl_chroma_geom
  import scl_phase_pkg::*;
#(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned PH_FRAC = 13,
  parameter int unsigned VST_W   = 16,
  parameter int unsigned HST_W   = 19
) (
  input  logic [RES_W-1:0]      src_w_i,
  input  logic [RES_W-1:0]      src_h_i,
  input  logic [RES_W-1:0]      dst_w_i,
  input  logic [RES_W-1:0]      dst_h_i,
  input  logic [1:0]            src_fmt_i,
  input  logic [1:0]            dst_fmt_i,
  input  logic [2:0]            siting_i,
  output logic [RES_W-1:0]      src_cw_o,
  output logic [RES_W-1:0]      src_ch_o,
  output logic [RES_W-1:0]      dst_cw_o,
  output logic [RES_W-1:0]      dst_ch_o,
  output logic [VST_W-1:0]      vstart_o,
  output logic [HST_W-1:0]      hstart_o,
  output logic [RES_WORD_W-1:0] src_luma_res_o,
  output logic [RES_WORD_W-1:0] src_chr_res_o,
  output logic [RES_WORD_W-1:0] dst_luma_res_o,
  output logic [RES_WORD_W-1:0] dst_chr_res_o
);
  localparam int unsigned QTR  = 2 ** (PH_FRAC - 2);
  localparam int unsigned HALF = 2 ** (PH_FRAC - 1);
  localparam logic [VST_W-1:0] V_QTR  = ~VST_W'(QTR) + 1'b1;
  localparam logic [VST_W-1:0] V_HALF = ~VST_W'(HALF) + 1'b1;
  localparam logic [HST_W-1:0] H_QTR  = ~HST_W'(QTR) + 1'b1;

  logic src_420, src_sub_w, src_full, dst_422, trim_h;
  logic [RES_W-1:0] src_lh_enc, src_ch_enc;

  always_comb begin
    src_420   = (pix_fmt_e'(src_fmt_i) == FMT_420);
    src_sub_w = src_420 || (pix_fmt_e'(src_fmt_i) == FMT_422);
    src_full  = !src_sub_w;
    dst_422   = (pix_fmt_e'(dst_fmt_i) == FMT_422);
    trim_h    = src_full && dst_422;

    src_cw_o = src_sub_w ? (src_w_i >> 1) : src_w_i;
    src_ch_o = src_420   ? (src_h_i >> 1) : src_h_i;
    dst_cw_o = dst_422   ? (dst_w_i >> 1) : dst_w_i;
    dst_ch_o = dst_h_i;

    vstart_o = '0;
    hstart_o = '0;
    if (src_420) begin
      case (siting_i)
        3'd0, 3'd1: vstart_o = V_QTR;
        3'd4, 3'd5: vstart_o = V_HALF;
        default:    vstart_o = '0;
      endcase
      if (siting_i[0] && siting_i != 3'd7) hstart_o = H_QTR;
    end

    src_lh_enc = src_h_i  - RES_W'(trim_h);
    src_ch_enc = src_ch_o - RES_W'(trim_h);
    src_luma_res_o = enc_res(RES_FLD_W'(src_w_i),  RES_FLD_W'(src_lh_enc));
    src_chr_res_o  = enc_res(RES_FLD_W'(src_cw_o), RES_FLD_W'(src_ch_enc));
    dst_luma_res_o = enc_res(RES_FLD_W'(dst_w_i),  RES_FLD_W'(dst_h_i));
    dst_chr_res_o  = enc_res(RES_FLD_W'(dst_cw_o), RES_FLD_W'(dst_ch_o));
  end
endmodule

// File: rtl/scl_rdiv.sv
module scl_rdiv #(
  parameter int unsigned DVD_W = 26,
  parameter int unsigned DVS_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(DVD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic [DVD_W-1:0] q_q;
  logic [DVS_W:0]   r_q, r_sh, r_nx;
  logic [DVS_W-1:0] d_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, ge;

  always_comb begin
    r_sh = {r_q[DVS_W-1:0], q_q[DVD_W-1]};
    ge   = (r_sh >= {1'b0, d_q});
    r_nx = ge ? (r_sh - {1'b0, d_q}) : r_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; r_q <= '0; d_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        q_q <= dvd_i; r_q <= '0; d_q <= dvs_i; cnt_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        q_q   <= {q_q[DVD_W-2:0], ge};
        r_q   <= r_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = q_q;

  // R1
  rem_below_dvs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && d_q != '0) |-> (r_q < {1'b0, d_q}));
endmodule

// File: rtl/scl_inc_seq.sv
module scl_inc_seq #(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned PH_FRAC = 13,
  parameter int unsigned INC_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       go_i,
  input  logic [3:0][RES_W-1:0]      src_sz_i,
  input  logic [3:0][RES_W-1:0]      dst_sz_i,
  output logic [3:0][INC_W-1:0]      inc_o,
  output logic                       busy_o,
  output logic                       done_o
);
  localparam int unsigned DVD_W = RES_W + PH_FRAC + 1;

  typedef enum logic [1:0] {S_IDLE, S_KICK, S_WAIT} seq_st_e;

  seq_st_e              st_q;
  logic [1:0]           idx_q;
  logic [3:0][INC_W-1:0] inc_q;
  logic                 done_q, div_go, div_busy, div_done;
  logic [DVD_W-1:0]     dvd, quo;

  assign div_go = (st_q == S_KICK);
  assign dvd = {1'b0, src_sz_i[idx_q], {PH_FRAC{1'b0}}} + DVD_W'(dst_sz_i[idx_q] >> 1);

  scl_rdiv #(.DVD_W(DVD_W), .DVS_W(RES_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (div_go),
    .dvd_i (dvd),
    .dvs_i (dst_sz_i[idx_q]),
    .busy_o(div_busy),
    .done_o(div_done),
    .quo_o (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; idx_q <= '0; inc_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (go_i) begin st_q <= S_KICK; idx_q <= '0; end
        S_KICK: st_q <= S_WAIT;
        S_WAIT: if (div_done) begin
          inc_q[idx_q] <= quo[INC_W-1:0];
          if (idx_q == 2'd3) begin
            st_q <= S_IDLE; done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1; st_q <= S_KICK;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign inc_o  = inc_q;
  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8
  inc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !go_i) |=> $stable(inc_q));
  // R7
  div_idle_at_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_KICK) |-> !div_busy);
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_phase_pkg::*;
#(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned PH_FRAC = 13,
  parameter int unsigned INC_W   = 16,
  parameter int unsigned VST_W   = 16,
  parameter int unsigned HST_W   = 19
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [RES_W-1:0]      src_w_i,
  input  logic [RES_W-1:0]      src_h_i,
  input  logic [RES_W-1:0]      dst_w_i,
  input  logic [RES_W-1:0]      dst_h_i,
  input  logic [1:0]            src_fmt_i,
  input  logic [1:0]            dst_fmt_i,
  input  logic [2:0]            siting_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [INC_W-1:0]      luma_vinc_o,
  output logic [INC_W-1:0]      luma_hinc_o,
  output logic [INC_W-1:0]      chr_vinc_o,
  output logic [INC_W-1:0]      chr_hinc_o,
  output logic [VST_W-1:0]      chr_vstart_o,
  output logic [HST_W-1:0]      chr_hstart_o,
  output logic [RES_WORD_W-1:0] src_luma_res_o,
  output logic [RES_WORD_W-1:0] src_chr_res_o,
  output logic [RES_WORD_W-1:0] dst_luma_res_o,
  output logic [RES_WORD_W-1:0] dst_chr_res_o
);
  logic [RES_W-1:0] g_src_cw, g_src_ch, g_dst_cw, g_dst_ch;
  logic [VST_W-1:0] g_vst;
  logic [HST_W-1:0] g_hst;
  logic [RES_WORD_W-1:0] g_slr, g_scr, g_dlr, g_dcr;

  logic [3:0][RES_W-1:0] src_sz_q, dst_sz_q;
  logic [3:0][INC_W-1:0] inc;
  logic [VST_W-1:0] vst_q;
  logic [HST_W-1:0] hst_q;
  logic [RES_WORD_W-1:0] slr_q, scr_q, dlr_q, dcr_q;
  logic seq_busy, accept;

  scl_chroma_geom #(.RES_W(RES_W), .PH_FRAC(PH_FRAC), .VST_W(VST_W), .HST_W(HST_W)) u_geom (
    .src_w_i(src_w_i), .src_h_i(src_h_i), .dst_w_i(dst_w_i), .dst_h_i(dst_h_i),
    .src_fmt_i(src_fmt_i), .dst_fmt_i(dst_fmt_i), .siting_i(siting_i),
    .src_cw_o(g_src_cw), .src_ch_o(g_src_ch), .dst_cw_o(g_dst_cw), .dst_ch_o(g_dst_ch),
    .vstart_o(g_vst), .hstart_o(g_hst),
    .src_luma_res_o(g_slr), .src_chr_res_o(g_scr),
    .dst_luma_res_o(g_dlr), .dst_chr_res_o(g_dcr)
  );

  assign accept = start_i && !seq_busy;

  // slot order: luma v, luma h, chroma v, chroma h
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_sz_q <= '0; dst_sz_q <= '0; vst_q <= '0; hst_q <= '0;
      slr_q <= '0; scr_q <= '0; dlr_q <= '0; dcr_q <= '0;
    end else if (accept) begin
      src_sz_q <= {g_src_cw, g_src_ch, src_w_i, src_h_i};
      dst_sz_q <= {g_dst_cw, g_dst_ch, dst_w_i, dst_h_i};
      vst_q <= g_vst; hst_q <= g_hst;
      slr_q <= g_slr; scr_q <= g_scr; dlr_q <= g_dlr; dcr_q <= g_dcr;
    end
  end

  scl_inc_seq #(.RES_W(RES_W), .PH_FRAC(PH_FRAC), .INC_W(INC_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(accept),
    .src_sz_i(src_sz_q), .dst_sz_i(dst_sz_q),
    .inc_o(inc), .busy_o(seq_busy), .done_o(done_o)
  );

  assign busy_o         = seq_busy;
  assign luma_vinc_o    = inc[0];
  assign luma_hinc_o    = inc[1];
  assign chr_vinc_o     = inc[2];
  assign chr_hinc_o     = inc[3];
  assign chr_vstart_o   = vst_q;
  assign chr_hstart_o   = hst_q;
  assign src_luma_res_o = slr_q;
  assign src_chr_res_o  = scr_q;
  assign dst_luma_res_o = dlr_q;
  assign dst_chr_res_o  = dcr_q;

  // R3
  vstart_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_vstart_o != '0) |-> chr_vstart_o[VST_W-1]);
  // R4
  hstart_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_hstart_o != '0) |-> chr_hstart_o[HST_W-1]);
  // R7
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> ($stable(src_sz_q) && $stable(dst_sz_q) && $stable(slr_q)));
  // R7
  done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
endmodule

// File: tb/sim_scl_phase_calc.sv
module sim_scl_phase_calc;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [11:0] sw = '0, sh = '0, dw = '0, dh = '0;
  logic [1:0]  sf = '0, df = '0;
  logic [2:0]  sit = '0;
  logic busy, done;
  logic [15:0] lvi, lhi, cvi, chi, cvs;
  logic [18:0] chs;
  logic [31:0] slr, scr, dlr, dcr;

  int n_chk = 0, n_fail = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  scl_phase_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_w_i(sw), .src_h_i(sh), .dst_w_i(dw), .dst_h_i(dh),
    .src_fmt_i(sf), .dst_fmt_i(df), .siting_i(sit),
    .busy_o(busy), .done_o(done),
    .luma_vinc_o(lvi), .luma_hinc_o(lhi), .chr_vinc_o(cvi), .chr_hinc_o(chi),
    .chr_vstart_o(cvs), .chr_hstart_o(chs),
    .src_luma_res_o(slr), .src_chr_res_o(scr),
    .dst_luma_res_o(dlr), .dst_chr_res_o(dcr)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic longint inc_f(input int s, input int d);
    return ((longint'(s) * 8192 + d / 2) / d) & 64'hFFFF;
  endfunction

  function automatic longint res_f(input int w, input int h);
    return (longint'((h - 1) & 12'hFFF) << 16) | longint'((w - 1) & 12'hFFF);
  endfunction

  typedef struct {
    int sw, sh, dw, dh, sf, df, sit;
  } cfg_t;

  cfg_t cur;

  task automatic drive(input cfg_t c);
    sw = 12'(c.sw); sh = 12'(c.sh); dw = 12'(c.dw); dh = 12'(c.dh);
    sf = 2'(c.sf); df = 2'(c.df); sit = 3'(c.sit);
  endtask

  task automatic check_all(input cfg_t c);
    int scw, sch, dcw, dch, trim;
    longint ev, eh;
    scw = (c.sf <= 1) ? c.sw / 2 : c.sw;
    sch = (c.sf == 0) ? c.sh / 2 : c.sh;
    dcw = (c.df == 1) ? c.dw / 2 : c.dw;
    dch = c.dh;
    trim = (c.sf >= 2 && c.df == 1) ? 1 : 0;
    ev = 0; eh = 0;
    if (c.sf == 0) begin
      if (c.sit == 0 || c.sit == 1) ev = 64'hF800;
      if (c.sit == 4 || c.sit == 5) ev = 64'hF000;
      if (c.sit == 1 || c.sit == 3 || c.sit == 5) eh = 64'h7F800;
    end
    chk("R1 luma_vinc", lvi, inc_f(c.sh, c.dh));
    chk("R1 luma_hinc", lhi, inc_f(c.sw, c.dw));
    chk("R2 chr_vinc", cvi, inc_f(sch, dch));
    chk("R2 chr_hinc", chi, inc_f(scw, dcw));
    chk("R3 chr_vstart", cvs, ev);
    chk("R4 chr_hstart", chs, eh);
    chk("R6 src_luma_res", slr, res_f(c.sw, c.sh - trim));
    chk("R6 src_chr_res", scr, res_f(scw, sch - trim));
    chk("R5 dst_luma_res", dlr, res_f(c.dw, c.dh));
    chk("R5 dst_chr_res", dcr, res_f(dcw, dch));
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 done timeout got=0 exp=1");
    end
  endtask

  // run with optional ignored start injected mid-run
  task automatic run(input cfg_t c, input bit inject);
    cfg_t junk;
    @(negedge clk);
    drive(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", busy, 1);
    if (inject) begin
      repeat (20) @(negedge clk);
      junk = c;
      junk.sw = (c.sw % 4000) + 7; junk.dh = (c.dh % 3000) + 5;
      junk.sf = (c.sf + 1) % 4; junk.sit = (c.sit + 3) % 8;
      drive(junk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    chk("R7 busy low at done", busy, 0);
    check_all(c);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  function automatic int rnd(input int lo, input int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + int'((seed >> 8) % (hi - lo + 1));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", busy, 0); chk("R9 done", done, 0);
    chk("R9 lvinc", lvi, 0); chk("R9 chinc", chi, 0);
    chk("R9 vstart", cvs, 0); chk("R9 hstart", chs, 0);
    chk("R9 slr", slr, 0); chk("R9 dcr", dcr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // format x siting sweep, down and up scaling
    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 8; s++) begin
        cur = '{1920, 1080, 1280, 720, f / 4, f % 4, s};
        run(cur, 1'b0);
        cur = '{640, 480, 1918, 1078, f / 4, f % 4, s};
        run(cur, (s == 2));
      end
    end

    // boundaries: unity, extreme ratios, tiny heights
    cur = '{800, 600, 800, 600, 2, 2, 0}; run(cur, 1'b0);
    cur = '{4095, 4095, 2, 2, 0, 2, 1}; run(cur, 1'b0);
    cur = '{2, 2, 4095, 4095, 1, 2, 4}; run(cur, 1'b0);
    cur = '{4094, 1, 2, 1, 2, 1, 5}; run(cur, 1'b0);
    cur = '{3, 3, 3, 3, 3, 1, 7}; run(cur, 1'b1);

    // pseudo-random sizes
    for (int k = 0; k < 220; k++) begin
      cur = '{rnd(2, 4095), rnd(2, 4095), rnd(2, 4095), rnd(1, 4095),
              rnd(0, 3), rnd(0, 3), rnd(0, 7)};
      run(cur, (k % 9 == 0));
    end

    // R8 hold: inputs change without start
    sw = 12'd17; sh = 12'd33; dw = 12'd99; dh = 12'd5; sf = 2'd0; df = 2'd1; sit = 3'd5;
    repeat (40) @(negedge clk);
    chk("R8 busy stays low", busy, 0);
    check_all(cur);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule